// File: doc/BRIEF.md
# Conditional Relative Branch Resolver

This block decides whether a short-reach conditional jump is taken and produces the program counter that follows it. On each cycle where a request is presented, it reads a 4-bit condition selector, the four status flags (negative, zero, sign, carry), and a 6-bit displacement magnitude with a separate direction bit. It also reads the 16-bit address of the jump. One clock later it reports the decision and the next program counter.

The displacement is not two's complement. It is an unsigned magnitude that is added for a forward jump and subtracted for a backward one. Either way it is applied to the address of the word after the jump, so the reach is 63 words in each direction. Arithmetic wraps modulo 2^16. A pipeline's fetch stage uses the registered result to redirect or continue.

Top module: `branch_resolver`

## Requirements
- R1: While reset (active low) is held and before any request, `resValid`, `taken` and `nextPc` are all zero.
- R2: `resValid` is high in exactly the cycle after a cycle where `evalValid` was high, and low otherwise; each request yields one result, in order.
- R3: Selector 0 takes the jump when carry is 0; selector 1 takes it when carry is 1.
- R4: Selector 2 takes the jump when sign is 0; selector 3 takes it when sign is 1.
- R5: Selector 4 takes the jump when zero is 0, selector 5 when zero is 1, selector 6 when negative is 0, selector 7 when negative is 1.
- R6: Selector 9 ("above") takes the jump only when zero is 0 and carry is 1; selector 8 takes it in every other flag combination.
- R7: Selector 11 ("greater") takes the jump only when zero is 0 and sign is 0; selector 10 takes it in every other flag combination.
- R8: Selector 12 takes the jump when negative equals sign; selector 13 takes it when they differ.
- R9: Selectors 14 and 15 always take the jump, whatever the flags.
- R10: A jump that is not taken gives `nextPc` = `pcIn` + 1 modulo 2^16.
- R11: A taken jump with `dirBack` = 0 gives `nextPc` = `pcIn` + 1 + `dispMag` modulo 2^16.
- R12: A taken jump with `dirBack` = 1 gives `nextPc` = `pcIn` + 1 − `dispMag` modulo 2^16.
- R13: In cycles without a request, `taken` and `nextPc` keep their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evalValid | input | 1 | A jump is presented this cycle |
| condSel | input | 4 | Condition selector |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| flagC | input | 1 | Carry flag |
| dispMag | input | 6 | Unsigned displacement magnitude |
| dirBack | input | 1 | 1 = backward, 0 = forward |
| pcIn | input | 16 | Address of the jump word |
| resValid | output | 1 | Result valid this cycle |
| taken | output | 1 | Jump taken |
| nextPc | output | 16 | Next program counter |

## Verification
The assertions assume that `condSel`, the flags, `dispMag`, `dirBack` and `pcIn` are meaningful only while `evalValid` is high. They also assume those inputs are known in every cycle after reset, since results are tied to the previous cycle's inputs through `$past`. The stimulus drives every input to a defined value from time zero and changes inputs only on the falling edge. The cycles without a request deliberately scramble the other inputs, so the hold rule is exercised against real changes.

// File: rtl/brres_pkg.sv
package brres_pkg;

  localparam int COND_W   = 4;
  localparam int NUM_COND = 1 << COND_W;

  // Selector encoding: odd code = predicate true, even code = its negation
  typedef enum logic [COND_W-1:0] {
    CC_CARRY_CLR = 4'd0,
    CC_CARRY_SET = 4'd1,
    CC_SIGN_CLR  = 4'd2,
    CC_SIGN_SET  = 4'd3,
    CC_ZERO_CLR  = 4'd4,
    CC_ZERO_SET  = 4'd5,
    CC_NEG_CLR   = 4'd6,
    CC_NEG_SET   = 4'd7,
    CC_NOT_ABOVE = 4'd8,
    CC_ABOVE     = 4'd9,
    CC_NOT_GT    = 4'd10,
    CC_GT        = 4'd11,
    CC_NS_SAME   = 4'd12,
    CC_NS_DIFF   = 4'd13,
    CC_ALWAYS_A  = 4'd14,
    CC_ALWAYS_B  = 4'd15
  } cond_e;

  typedef struct packed {
    logic load;
    logic takeJump;
  } strobe_t;

endpackage

// File: rtl/brres_ctrl.sv
module brres_ctrl
  import brres_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [COND_W-1:0] condSel,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagC,
  output strobe_t           strobes
);

  localparam int NUM_PAIRS = NUM_COND / 2;

  logic [NUM_PAIRS-1:0] baseTerm;
  logic [NUM_COND-1:0]  condVec;

  // Predicate for each selector pair (odd member)
  always_comb begin
    baseTerm    = '0;
    baseTerm[0] = flagC;
    baseTerm[1] = flagS;
    baseTerm[2] = flagZ;
    baseTerm[3] = flagN;
    baseTerm[4] = ~flagZ & flagC;
    baseTerm[5] = ~flagZ & ~flagS;
    baseTerm[6] = flagN ^ flagS;
    baseTerm[7] = 1'b1;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (p == NUM_PAIRS - 1) begin : g_uncond
      assign condVec[2*p]   = 1'b1;
      assign condVec[2*p+1] = 1'b1;
    end else begin : g_cond
      assign condVec[2*p]   = ~baseTerm[p];
      assign condVec[2*p+1] =  baseTerm[p];
    end
  end

  always_comb begin
    strobes.load     = evalValid;
    strobes.takeJump = condVec[condSel];
  end

  // R9: unconditional selectors never depend on flags
  p_uncond_taken_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condSel[COND_W-1:1] == 3'b111) |-> strobes.takeJump);

  // R6: "above" is refused whenever zero is set
  p_above_needs_nz_r6: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condSel == CC_ABOVE && flagZ) |-> !strobes.takeJump);

  // R7: "greater" is refused whenever sign is set
  p_gt_needs_ns_r7: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && condSel == CC_GT && flagS) |-> !strobes.takeJump);

endmodule

// File: rtl/brres_dpath.sv
module brres_dpath
  import brres_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [DISP_W-1:0] dispMag,
  input  logic              dirBack,
  output logic              resValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  logic [PC_W-1:0] fallThru;
  logic [PC_W-1:0] dispExt;
  logic [PC_W-1:0] jumpTarget;
  logic [PC_W-1:0] pcSel;

  always_comb begin
    fallThru   = pcIn + PC_STEP;
    dispExt    = PC_W'(dispMag);
    jumpTarget = dirBack ? (fallThru - dispExt) : (fallThru + dispExt);
    pcSel      = strobes.takeJump ? jumpTarget : fallThru;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) begin
        taken  <= strobes.takeJump;
        nextPc <= pcSel;
      end
    end
  end

  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> resValid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> !resValid);

  p_fallthru_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.takeJump) |=> (nextPc == $past(pcIn) + PC_STEP));

  p_forward_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.takeJump && !dirBack)
      |=> (nextPc == $past(pcIn) + PC_STEP + PC_W'($past(dispMag))));

  p_backward_r12: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.takeJump && dirBack)
      |=> (nextPc == $past(pcIn) + PC_STEP - PC_W'($past(dispMag))));

  p_hold_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(nextPc) && $stable(taken)));

endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalValid,
  input  logic [COND_W-1:0] condSel,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagC,
  input  logic [DISP_W-1:0] dispMag,
  input  logic              dirBack,
  input  logic [PC_W-1:0]   pcIn,
  output logic              resValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc
);

  strobe_t strobes;

  brres_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evalValid (evalValid),
    .condSel   (condSel),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .flagS     (flagS),
    .flagC     (flagC),
    .strobes   (strobes)
  );

  brres_dpath #(
    .PC_W   (PC_W),
    .DISP_W (DISP_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pcIn     (pcIn),
    .dispMag  (dispMag),
    .dirBack  (dirBack),
    .resValid (resValid),
    .taken    (taken),
    .nextPc   (nextPc)
  );

endmodule

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalValid = 1'b0;
  logic [3:0]  condSel = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagS = 1'b0, flagC = 1'b0;
  logic [5:0]  dispMag = '0;
  logic        dirBack = 1'b0;
  logic [15:0] pcIn = '0;
  logic        resValid, taken;
  logic [15:0] nextPc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          qTaken[$];
  logic [15:0] qPc[$];
  string       qTakeTag[$];
  string       qPcTag[$];

  branch_resolver u_branch_resolver (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .condSel(condSel),
    .flagN(flagN), .flagZ(flagZ), .flagS(flagS), .flagC(flagC),
    .dispMag(dispMag), .dirBack(dirBack), .pcIn(pcIn),
    .resValid(resValid), .taken(taken), .nextPc(nextPc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit refTake(input logic [3:0] cc, input bit n, z, s, c);
    case (cc)
      4'd0:  return !c;
      4'd1:  return c;
      4'd2:  return !s;
      4'd3:  return s;
      4'd4:  return !z;
      4'd5:  return z;
      4'd6:  return !n;
      4'd7:  return n;
      4'd8:  return !(!z && c);
      4'd9:  return !z && c;
      4'd10: return !(!z && !s);
      4'd11: return !z && !s;
      4'd12: return n == s;
      4'd13: return n != s;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string condTag(input logic [3:0] cc);
    if (cc < 2)  return "R3";
    if (cc < 4)  return "R4";
    if (cc < 8)  return "R5";
    if (cc < 10) return "R6";
    if (cc < 12) return "R7";
    if (cc < 14) return "R8";
    return "R9";
  endfunction

  task automatic check1(input string tag, input logic [15:0] act, exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: present one request and push its expected result
  task automatic sendReq(input logic [3:0] cc, input logic [3:0] nzsc,
                         input logic [5:0] d, input bit back, input logic [15:0] pc);
    bit tk;
    logic [15:0] exp;
    @(negedge clk);
    evalValid = 1'b1; condSel = cc;
    {flagN, flagZ, flagS, flagC} = nzsc;
    dispMag = d; dirBack = back; pcIn = pc;
    tk  = refTake(cc, nzsc[3], nzsc[2], nzsc[1], nzsc[0]);
    exp = pc + 16'd1;
    if (tk) exp = back ? exp - {10'd0, d} : exp + {10'd0, d};
    qTaken.push_back(tk);
    qPc.push_back(exp);
    qTakeTag.push_back(condTag(cc));
    qPcTag.push_back(tk ? (back ? "R12" : "R11") : "R10");
  endtask

  task automatic goIdle();
    @(negedge clk);
    evalValid = 1'b0;
  endtask

  // Monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (rstN && !done && resValid === 1'b1) begin
      if (qTaken.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 result with no request: actual 1 expected 0");
      end else begin
        check1(qTakeTag.pop_front(), {15'd0, taken}, {15'd0, qTaken.pop_front()}, "taken");
        check1(qPcTag.pop_front(), nextPc, qPc.pop_front(), "nextPc");
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] holdPc;
    logic        holdTk;
    // R1: reset state
    repeat (2) @(negedge clk);
    check1("R1", {15'd0, resValid}, 16'd0, "resValid in reset");
    check1("R1", {15'd0, taken},    16'd0, "taken in reset");
    check1("R1", nextPc,            16'd0, "nextPc in reset");
    rstN = 1'b1;
    @(negedge clk);
    check1("R1", {15'd0, resValid}, 16'd0, "resValid after reset");

    // Every selector against every flag combination, back to back
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        sendReq(4'(cc), 4'(f), 6'($urandom), 1'($urandom), 16'($urandom));
      end
    end
    goIdle();
    @(negedge clk);

    // Boundary cases R10, R11, R12
    sendReq(4'd14, 4'd0, 6'd0,  1'b0, 16'hFFFF); // taken, zero disp: wrap to 0
    sendReq(4'd9,  4'd4, 6'd63, 1'b0, 16'hFFFF); // R10: not taken wraps to 0
    sendReq(4'd15, 4'd0, 6'd63, 1'b0, 16'hFFF0); // R11: forward max wraps
    sendReq(4'd14, 4'd0, 6'd63, 1'b1, 16'h0000); // R12: backward max wraps
    sendReq(4'd11, 4'd0, 6'd63, 1'b1, 16'h1000); // R12: gt taken backward
    sendReq(4'd13, 4'd8, 6'd1,  1'b1, 16'h0000); // R12: to FFFF... 0+1-1=0
    goIdle();
    // R2: a lone request gives a single result
    @(negedge clk);
    check1("R2", {15'd0, resValid}, 16'd0, "resValid while idle");

    // R13: hold during idle with scrambled inputs
    sendReq(4'd1, 4'd1, 6'd20, 1'b0, 16'h4000);
    holdTk = 1'b1; holdPc = 16'h4015;
    @(negedge clk);
    evalValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      condSel = 4'(k * 5); {flagN, flagZ, flagS, flagC} = 4'(k + 3);
      dispMag = 6'(k * 17); dirBack = 1'(k); pcIn = 16'($urandom);
      @(negedge clk);
      check1("R13", {15'd0, taken}, {15'd0, holdTk}, "taken held");
      check1("R13", nextPc, holdPc, "nextPc held");
      check1("R2", {15'd0, resValid}, 16'd0, "resValid while idle");
    end

    repeat (2) @(negedge clk);
    check1("R2", 16'(qTaken.size()), 16'd0, "pending results");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule